// File: doc/BRIEF.md
# SPI Master Transfer Timing Sequencer

This block produces the serial clock, the chip-select framing and the programmable gaps for an SPI master that works through a run of queued transfers. A small configuration register holds three values and two mode bits. The values are a baud divisor, a pre-clock gap count and a post-transfer gap count. The mode bits are clock polarity and clock phase. Software may write this register only while the sequencer is stopped. A separate start strobe sets the enable bit.

While enabled, the sequencer takes one queue entry at a time over a valid/ready handshake. Each entry names one of four chip selects and carries a data word. It also carries two flags, which choose between the programmed gaps and the fixed defaults, and a last-entry marker. For each entry the sequencer asserts chip select and waits out the pre-clock gap. It then makes 2×BITS clock edges, shifting the word out MSB first and sampling the input line. Finally it waits out the post-transfer gap and releases chip select. The enable bit clears itself when the marked last entry finishes, or at once on a mode fault.

Top module: `spi_seq_timer`

## Requirements
- R1: After reset: `sck` is low, `cs_n` is 4'b1111, and `enable`, `busy`, `done` and `ent_ready` are low. The baud divisor resets to 4 and both gap counts reset to 4.
- R2: Each `sck` half period lasts exactly as many system clocks as the baud divisor. A transfer makes exactly 2×BITS clock edges (16 for BITS = 8), and the clock ends at its idle level.
- R3: With a baud divisor of 0 or 1, `ent_ready` stays low, no entry is accepted, `cs_n` stays 4'b1111 and `sck` holds its idle level.
- R4: When the entry's pre-clock flag is set, the first `sck` edge comes exactly N system clocks after chip select goes low, where N is the 7-bit pre-clock count (1 to 127). A count of 0 gives 128.
- R5: When the entry's pre-clock flag is clear, that gap equals one half period of the serial clock, which is the baud divisor in system clocks.
- R6: When the entry's post-transfer flag is set, chip select is released 32×M system clocks after the last `sck` edge, where M is the 8-bit post count. A count of 0 gives 8192.
- R7: When the entry's post-transfer flag is clear, chip select is released 17 system clocks after the last `sck` edge.
- R8: During a transfer, only the `cs_n` bit indexed by the entry's 2-bit select field is low. At all times no more than one bit of `cs_n` is low.
- R9: A `start` pulse sets `enable`, and `busy` follows `enable`. Releasing chip select for an entry whose last flag is set clears `enable`. In that same cycle `done` pulses high for exactly one system clock. An entry without the last flag leaves `enable` set.
- R10: A `mode_fault` pulse clears `enable` on the next edge. It releases all chip selects, returns `sck` to idle and produces no `done` pulse.
- R11: `sck` idles at the level of the clock polarity bit. With phase 0, `miso` is sampled on the leading edges; with phase 1, on the trailing edges. `mosi` changes on the opposite edges, MSB first. At the end of the shifting, `rx_valid` pulses for one cycle and `rx_data` holds the received word.
- R12: Configuration writes made while `enable` is high are ignored. The divisor, the gap counts and the mode bits keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe, honoured only while stopped |
| cfg_baud | input | 8 | Baud divisor |
| cfg_pre | input | 7 | Pre-clock gap count |
| cfg_post | input | 8 | Post-transfer gap count |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase (0: sample on leading edge) |
| start | input | 1 | Sets the enable bit |
| ent_valid | input | 1 | Queue entry available |
| ent_ready | output | 1 | Sequencer can take an entry this cycle |
| ent_pre_en | input | 1 | Use the programmed pre-clock gap |
| ent_post_en | input | 1 | Use the programmed post-transfer gap |
| ent_cs | input | 2 | Chip-select index |
| ent_last | input | 1 | Entry ends the queue |
| ent_data | input | BITS | Word to transmit |
| mode_fault | input | 1 | Abort and clear enable |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 4 | Active-low chip selects |
| rx_data | output | BITS | Received word |
| rx_valid | output | 1 | One-cycle strobe marking `rx_data` valid |
| enable | output | 1 | Enable bit |
| busy | output | 1 | High while enabled |
| done | output | 1 | One-cycle pulse when the queue finishes |

## Verification
A wrong count value or a wrong reload shows at the pins within one gap. The edge-to-edge spacing of `sck`, the gap from `cs_n` falling to the first edge, or the gap from the last edge to `cs_n` rising would be off by the error. The bench measures each of these in system clocks for every flag and encoding. A wrong edge index or phase decode gives a wrong edge count, or a looped-back word that differs from the one sent, by the end of that same transfer. A stuck enable or a lost last flag shows as a missing or repeated `done`, or as `ent_ready` reasserting, in the cycle after the last chip-select release.

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_baud,
  input  logic [6:0]      cfg_pre,
  input  logic [7:0]      cfg_post,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            start,
  input  logic            ent_valid,
  output logic            ent_ready,
  input  logic            ent_pre_en,
  input  logic            ent_post_en,
  input  logic [1:0]      ent_cs,
  input  logic            ent_last,
  input  logic [BITS-1:0] ent_data,
  input  logic            mode_fault,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic [3:0]      cs_n,
  output logic [BITS-1:0] rx_data,
  output logic            rx_valid,
  output logic            enable,
  output logic            busy,
  output logic            done
);
  localparam int CW = 13;
  localparam int EW = $clog2(2 * BITS);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * BITS - 1);
  localparam logic [CW-1:0] STD_POST  = CW'(16);
  localparam logic [CW-1:0] MAX_POST  = CW'(8191);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_SHIFT, S_POST} st_t;

  st_t             st;
  logic [7:0]      baud_r, post_r;
  logic [6:0]      pre_r;
  logic            cpol_r, cpha_r, en_r;
  logic [CW-1:0]   cnt;
  logic [EW-1:0]   eidx;
  logic            sck_r, post_f, last_f, rxv_r, done_r;
  logic [BITS-1:0] tx, rx;
  logic [3:0]      csn_r;

  logic            baud_ok, accept, tick, lead, smp_e, chg_e, edge_now, fin_edge;
  logic [CW-1:0]   half, pre_load, post_load;

  assign baud_ok   = baud_r >= 8'd2;
  assign ent_ready = en_r && (st == S_IDLE) && baud_ok;
  assign accept    = ent_ready && ent_valid;
  assign tick      = (cnt == '0);
  assign lead      = ~eidx[0];
  assign smp_e     = cpha_r ? ~lead : lead;
  assign chg_e     = cpha_r ? (lead && eidx != '0) : ~lead;
  assign edge_now  = (st == S_PRE || st == S_SHIFT) && tick;
  assign fin_edge  = (eidx == LAST_EDGE);

  assign half      = {5'b0, baud_r} - CW'(1);
  assign pre_load  = ent_pre_en ? {6'b0, 7'(pre_r - 7'd1)} : half;
  assign post_load = !post_f         ? STD_POST :
                     (post_r == 8'd0) ? MAX_POST :
                     {post_r, 5'b0} - CW'(1);

  assign sck      = sck_r ^ cpol_r;
  assign mosi     = tx[BITS-1];
  assign cs_n     = csn_r;
  assign rx_data  = rx;
  assign rx_valid = rxv_r;
  assign enable   = en_r;
  assign busy     = en_r;
  assign done     = done_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_r <= 8'd4;
      pre_r  <= 7'd4;
      post_r <= 8'd4;
      cpol_r <= 1'b0;
      cpha_r <= 1'b0;
      en_r   <= 1'b0;
      st     <= S_IDLE;
      cnt    <= '0;
      eidx   <= '0;
      sck_r  <= 1'b0;
      post_f <= 1'b0;
      last_f <= 1'b0;
      tx     <= '0;
      rx     <= '0;
      rxv_r  <= 1'b0;
      done_r <= 1'b0;
      csn_r  <= 4'b1111;
    end else begin
      rxv_r  <= 1'b0;
      done_r <= 1'b0;
      if (cfg_we && !en_r) begin
        baud_r <= cfg_baud;
        pre_r  <= cfg_pre;
        post_r <= cfg_post;
        cpol_r <= cfg_cpol;
        cpha_r <= cfg_cpha;
      end
      if (start) en_r <= 1'b1;
      if (mode_fault) begin
        en_r  <= 1'b0;
        st    <= S_IDLE;
        csn_r <= 4'b1111;
        sck_r <= 1'b0;
        eidx  <= '0;
        cnt   <= '0;
      end else begin
        case (st)
          S_IDLE: if (accept) begin
            csn_r  <= ~(4'b0001 << ent_cs);
            tx     <= ent_data;
            post_f <= ent_post_en;
            last_f <= ent_last;
            cnt    <= pre_load;
            eidx   <= '0;
            st     <= S_PRE;
          end
          S_PRE, S_SHIFT: if (edge_now) begin
            sck_r <= ~sck_r;
            if (smp_e) rx <= {rx[BITS-2:0], miso};
            if (chg_e) tx <= {tx[BITS-2:0], 1'b0};
            if (fin_edge) begin
              st    <= S_POST;
              cnt   <= post_load;
              eidx  <= '0;
              rxv_r <= 1'b1;
            end else begin
              st   <= S_SHIFT;
              cnt  <= half;
              eidx <= eidx + EW'(1);
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
          S_POST: if (tick) begin
            csn_r <= 4'b1111;
            st    <= S_IDLE;
            if (last_f) begin
              en_r   <= 1'b0;
              done_r <= 1'b1;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_seq_timer_chk.sv
module spi_seq_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic [3:0] cs_n,
  input logic       enable,
  input logic       done,
  input logic       mode_fault,
  input logic       cpol_q,
  input logic [7:0] baud_q
);
  a_r8_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r11_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> (sck == cpol_q));

  a_r3_slow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_q < 8'd2) |-> (&cs_n));

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !enable);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> (!enable && (&cs_n) && !done));
endmodule

bind spi_seq_timer spi_seq_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .enable(enable),
  .done(done), .mode_fault(mode_fault), .cpol_q(cpol_r), .baud_q(baud_r)
);

// File: tb/spi_seq_timer_tb.sv
module spi_seq_timer_tb;
  localparam int CLK_P = 10;
  localparam int BITS  = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_cpol = 0, cfg_cpha = 0, start = 0;
  logic [7:0] cfg_baud = 0, cfg_post = 0;
  logic [6:0] cfg_pre = 0;
  logic ent_valid = 0, ent_pre_en = 0, ent_post_en = 0, ent_last = 0, mode_fault = 0;
  logic [1:0] ent_cs = 0;
  logic [BITS-1:0] ent_data = 0;
  logic ent_ready, sck, mosi, miso, rx_valid, enable, busy, done;
  logic [3:0] cs_n;
  logic [BITS-1:0] rx_data;

  assign miso = mosi;
  always #(CLK_P/2) clk = ~clk;

  spi_seq_timer #(.BITS(BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_baud(cfg_baud), .cfg_pre(cfg_pre),
    .cfg_post(cfg_post), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .start(start),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_pre_en(ent_pre_en),
    .ent_post_en(ent_post_en), .ent_cs(ent_cs), .ent_last(ent_last), .ent_data(ent_data),
    .mode_fault(mode_fault), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .rx_data(rx_data), .rx_valid(rx_valid), .enable(enable), .busy(busy), .done(done)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0, t_cs = 0, t_e1 = 0, t_prev = 0, t_rel = 0, n_edges = 0;
  int hp_min = 0, hp_max = 0, done_cnt = 0;
  logic [3:0] cs_seen = 4'hF, prev_cs = 4'hF;
  logic prev_sck = 0;
  logic [BITS-1:0] rx_got = 0;

  always @(negedge clk) begin
    cyc++;
    if (&prev_cs && !(&cs_n)) begin
      t_cs = cyc; n_edges = 0; hp_min = 1000000; hp_max = 0; cs_seen = cs_n;
    end
    if (!(&cs_n) && sck !== prev_sck) begin
      if (n_edges == 0) t_e1 = cyc;
      else begin
        if (cyc - t_prev < hp_min) hp_min = cyc - t_prev;
        if (cyc - t_prev > hp_max) hp_max = cyc - t_prev;
      end
      t_prev = cyc;
      n_edges++;
    end
    if (!(&prev_cs) && &cs_n) t_rel = cyc;
    if (done) done_cnt++;
    if (rx_valid) rx_got = rx_data;
    prev_cs = cs_n;
    prev_sck = sck;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input logic [7:0] b, input logic [6:0] p, input logic [7:0] q,
                           input logic pol, input logic pha);
    @(negedge clk);
    cfg_we = 1; cfg_baud = b; cfg_pre = p; cfg_post = q; cfg_cpol = pol; cfg_cpha = pha;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic go();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic offer(input logic pe, input logic po, input logic [1:0] cs,
                       input logic [BITS-1:0] d, input logic lst);
    logic r;
    ent_pre_en = pe; ent_post_en = po; ent_cs = cs; ent_data = d; ent_last = lst;
    ent_valid = 1;
    for (int i = 0; i < 200; i++) begin
      r = ent_ready;
      @(posedge clk);
      if (r) break;
    end
    @(negedge clk);
    ent_valid = 0;
  endtask

  task automatic xfer(input logic pe, input logic po, input logic [1:0] cs,
                      input logic [BITS-1:0] d, input logic lst);
    done_cnt = 0;
    offer(pe, po, cs, d, lst);
    for (int i = 0; i < 20000 && !(&cs_n); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 sck", sck, 0);
    chk("R1 cs_n", cs_n, 4'hF);
    chk("R1 enable", enable, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ready", ent_ready, 0);
  endtask

  task automatic t_defaults();
    go();
    chk("R9 busy after start", busy, 1);
    xfer(1, 1, 2'd0, 8'hA5, 1);
    chk("R1 default half period min", hp_min, 4);
    chk("R1 default half period max", hp_max, 4);
    chk("R1 default pre gap", t_e1 - t_cs, 4);
    chk("R1 default post gap", t_rel - t_prev, 128);
    chk("R2 edge count", n_edges, 16);
    chk("R8 cs0", cs_seen, 4'b1110);
    chk("R11 rx mode0", rx_got, 8'hA5);
    chk("R9 enable cleared", enable, 0);
    chk("R9 done pulses", done_cnt, 1);
  endtask

  task automatic t_std_gaps();
    configure(8'd2, 7'd9, 8'd9, 0, 0);
    go();
    xfer(0, 0, 2'd2, 8'h3C, 0);
    chk("R2 half period 2", hp_max, 2);
    chk("R5 pre = half period", t_e1 - t_cs, 2);
    chk("R7 standard post", t_rel - t_prev, 17);
    chk("R8 cs2", cs_seen, 4'b1011);
    chk("R9 enable kept", enable, 1);
    chk("R9 no done", done_cnt, 0);
    configure(8'd9, 7'd1, 8'd1, 1, 1);
    chk("R12 sck idle unchanged", sck, 0);
    xfer(0, 0, 2'd1, 8'hC3, 1);
    chk("R12 half period kept", hp_min, 2);
    chk("R12 half period kept max", hp_max, 2);
    chk("R11 rx after ignored write", rx_got, 8'hC3);
    chk("R9 done on last", done_cnt, 1);
  endtask

  task automatic t_long_gaps();
    configure(8'd3, 7'd127, 8'd0, 1, 1);
    chk("R11 idle high", sck, 1);
    go();
    xfer(1, 1, 2'd1, 8'h96, 1);
    chk("R4 pre 127", t_e1 - t_cs, 127);
    chk("R6 post 0 gives 8192", t_rel - t_prev, 8192);
    chk("R2 half period 3", hp_max, 3);
    chk("R11 rx mode3", rx_got, 8'h96);
    chk("R11 idle high after", sck, 1);
  endtask

  task automatic t_slow_clock();
    configure(8'd255, 7'd1, 8'd255, 0, 1);
    go();
    xfer(1, 1, 2'd3, 8'h81, 1);
    chk("R4 pre 1", t_e1 - t_cs, 1);
    chk("R6 post 255", t_rel - t_prev, 8160);
    chk("R2 half period 255", hp_min, 255);
    chk("R8 cs3", cs_seen, 4'b0111);
    chk("R11 rx mode1", rx_got, 8'h81);
  endtask

  task automatic t_mode2();
    configure(8'd5, 7'd0, 8'd1, 1, 0);
    go();
    xfer(0, 1, 2'd0, 8'h5A, 0);
    chk("R5 pre half period 5", t_e1 - t_cs, 5);
    chk("R6 post 1", t_rel - t_prev, 32);
    chk("R11 rx mode2", rx_got, 8'h5A);
    xfer(1, 0, 2'd0, 8'h0F, 1);
    chk("R4 pre 0 gives 128", t_e1 - t_cs, 128);
    chk("R7 standard post again", t_rel - t_prev, 17);
  endtask

  task automatic t_disabled_baud(input logic [7:0] b);
    int seen_ready, seen_cs;
    configure(b, 7'd4, 8'd4, 1, 0);
    go();
    seen_ready = 0; seen_cs = 0;
    ent_valid = 1; ent_cs = 2'd1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ent_ready) seen_ready++;
      if (!(&cs_n) || sck != 1'b1) seen_cs++;
    end
    ent_valid = 0;
    chk("R3 no ready at low divisor", seen_ready, 0);
    chk("R3 lines quiet at low divisor", seen_cs, 0);
    @(negedge clk); mode_fault = 1;
    @(negedge clk); mode_fault = 0;
    chk("R10 fault clears idle enable", enable, 0);
  endtask

  task automatic t_fault();
    configure(8'd4, 7'd4, 8'd4, 0, 0);
    go();
    done_cnt = 0;
    offer(1, 1, 2'd2, 8'hFF, 1);
    repeat (10) @(negedge clk);
    chk("R10 mid transfer cs", cs_n, 4'b1011);
    mode_fault = 1;
    @(negedge clk); mode_fault = 0;
    chk("R10 enable cleared", enable, 0);
    chk("R10 cs released", cs_n, 4'hF);
    chk("R10 sck idle", sck, 0);
    repeat (40) @(negedge clk);
    chk("R10 no done", done_cnt, 0);
    chk("R10 stays released", cs_n, 4'hF);
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_std_gaps();
    t_long_gaps();
    t_slow_clock();
    t_mode2();
    t_disabled_baud(8'd0);
    t_disabled_baud(8'd1);
    t_fault();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule